// File: doc/BRIEF.md
# Table Descriptor Register Bank

This block keeps eight 64-bit descriptor registers that tell translation logic where each of its in-memory data tables sits and how many entries it may hold. Each register has a fixed, read-only type code chosen at build time. Registers with type code 0 are absent: they read as zero and drop every write. Software writes the valid, two-level, base and page-count fields.

For each table type the bank gives out the base field, the two-level flag and an effective entry limit. The limit is the smaller of two counts. One is the number of entries that fit in the memory software allocated. The other is the number of IDs the implementation supports. Other logic gives the bank an index per type. The bank flags that index as out of range when it is greater than or equal to the limit, and it does this before any table access takes place.

Register layout, in bit positions: valid 63, two-level 62, type 58:56 (read-only), base 51:12, pages-minus-one 7:0. All other bits read zero.

Top module: `tbr_bank`

## Requirements
- R1: `reg_sel` (3 bits) picks one of eight registers, and `rd_data` shows that register combinationally.
- R2: The type field [58:56] is read-only. Register 0 reads type 1 (device table), register 1 reads type 2 (collection table), and registers 2 to 7 read type 0. Writes to these bits have no effect.
- R3: A register with type 0 reads as all zeros, and writes to it have no effect.
- R4: On a write to an implemented register, valid [63], two-level [62], base [51:12] and pages-minus-one [7:0] are stored on the clock edge. Every other bit except the type field reads zero.
- R5: After reset, every writable field is zero and every entry limit is zero.
- R6: For a flat table, the memory count is pages << (12 - esize_log2). The entry size is 8 bytes for device tables and 16 bytes for collection tables.
- R7: For a two-level table, the memory count is the flat count shifted left by a further 9 bits. This is 4 KiB pages with 8-byte first-level entries.
- R8: The entry limit is the minimum of the memory count and 2^idbits. The ID width is 16 bits for device tables and 12 bits for collection tables.
- R9: When the valid bit is clear, the entry limit is zero.
- R10: `tbl_base[t]` and `tbl_two_level[t]` show the stored fields of the register for type t (index 0 device, 1 collection).
- R11: `chk_bad[t]` is 1 exactly when `chk_idx[t]` >= `tbl_limit[t]`. It is combinational.
- R12: In the cycle where a register is written, index checks still use the value held before the edge. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write value |
| rd_data | output | 64 | Selected register contents |
| tbl_base | output | 2x40 | Base field per type |
| tbl_two_level | output | 2 | Two-level flag per type |
| tbl_limit | output | 2x17 | Effective entry limit per type |
| chk_idx | input | 2x32 | Index to check per type |
| chk_bad | output | 2 | Index out of range per type |

## Verification
A register write and an index check against the same table can fall in one cycle. The bench provokes this by driving a write to the device register and a boundary index in the same cycle. It then requires the out-of-range flag to follow the old limit before the edge and the new limit after it. Writes to absent registers are mixed into the random stream. Each one is judged by reading back all zeros and by checking that the limits stay as they were.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
   localparam int REG_CNT  = 8;
   localparam int SEL_W    = 3;
   localparam int DATA_W   = 64;
   localparam int TYPE_W   = 3;
   localparam int BASE_W   = 40;
   localparam int PAGES_W  = 8;
   localparam int VALID_B  = 63;
   localparam int TWO_B    = 62;
   localparam int TYPE_LO  = 56;
   localparam int BASE_LO  = 12;

   typedef struct packed {
      logic               valid;
      logic               two_lvl;
      logic [BASE_W-1:0]  base;
      logic [PAGES_W-1:0] pages_m1;
   } desc_t;
endpackage

// File: rtl/tbr_limit_calc.sv
module tbr_limit_calc
   import tbr_pkg::*;
#(
   parameter int PAGE_LOG2 = 12,
   parameter int L1_LOG2   = 3,
   parameter int ESZ_LOG2  = 3,
   parameter int ID_BITS   = 16,
   parameter int LIM_W     = 17
) (
   input  desc_t             desc,
   output logic [LIM_W-1:0]  limit
);
   localparam int MEM_W = PAGES_W + 1 + 2 * PAGE_LOG2;

   generate
      if (ESZ_LOG2 > PAGE_LOG2 || L1_LOG2 > PAGE_LOG2) begin : g_bad_size
         $error("entry size exceeds page size");
      end
      if (LIM_W <= ID_BITS || MEM_W <= ID_BITS) begin : g_bad_width
         $error("limit width too small for ID width");
      end
   endgenerate

   logic [MEM_W-1:0] pages, flat_cnt, mem_cnt, id_cnt, best;

   always_comb begin
      pages    = MEM_W'(desc.pages_m1) + MEM_W'(1);
      flat_cnt = pages << (PAGE_LOG2 - ESZ_LOG2);
      mem_cnt  = desc.two_lvl ? (flat_cnt << (PAGE_LOG2 - L1_LOG2)) : flat_cnt;
      id_cnt   = MEM_W'(1) << ID_BITS;
      best     = (mem_cnt < id_cnt) ? mem_cnt : id_cnt;
      limit    = desc.valid ? LIM_W'(best) : '0;
   end
endmodule

// File: rtl/tbr_desc_reg.sv
module tbr_desc_reg
   import tbr_pkg::*;
#(
   parameter int TYPE_CODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output desc_t             desc
);
   generate
      if (TYPE_CODE == 0) begin : g_absent
         assign desc    = '0;
         assign rd_data = '0;
      end else begin : g_present
         desc_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (wr_en) begin
               q.valid    <= wr_data[VALID_B];
               q.two_lvl  <= wr_data[TWO_B];
               q.base     <= wr_data[BASE_LO +: BASE_W];
               q.pages_m1 <= wr_data[PAGES_W-1:0];
            end
         end
         assign desc    = q;
         assign rd_data = {q.valid, q.two_lvl, 3'b000, TYPE_W'(TYPE_CODE),
                           4'b0000, q.base, 4'b0000, q.pages_m1};

         // R4
         wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (rd_data[VALID_B] == $past(wr_data[VALID_B]) &&
                       rd_data[TWO_B] == $past(wr_data[TWO_B]) &&
                       rd_data[BASE_LO +: BASE_W] == $past(wr_data[BASE_LO +: BASE_W]) &&
                       rd_data[PAGES_W-1:0] == $past(wr_data[PAGES_W-1:0])));
         // R2
         type_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> rd_data[TYPE_LO +: TYPE_W] == TYPE_W'(TYPE_CODE));
      end
   endgenerate
endmodule

// File: rtl/tbr_bank.sv
module tbr_bank
   import tbr_pkg::*;
#(
   parameter int NUM_TYPES = 2,
   parameter logic [REG_CNT*TYPE_W-1:0] TYPE_MAP = 24'h000011,
   parameter logic [NUM_TYPES-1:0][4:0] TYPE_ESZ_LOG2 = {5'd4, 5'd3},
   parameter logic [NUM_TYPES-1:0][4:0] TYPE_ID_BITS  = {5'd12, 5'd16},
   parameter int PAGE_LOG2 = 12,
   parameter int L1_LOG2   = 3,
   parameter int LIM_W     = 17,
   parameter int IDX_W     = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [SEL_W-1:0]                      reg_sel,
   input  logic                                  wr_en,
   input  logic [DATA_W-1:0]                     wr_data,
   output logic [DATA_W-1:0]                     rd_data,
   output logic [NUM_TYPES-1:0][BASE_W-1:0]      tbl_base,
   output logic [NUM_TYPES-1:0]                  tbl_two_level,
   output logic [NUM_TYPES-1:0][LIM_W-1:0]       tbl_limit,
   input  logic [NUM_TYPES-1:0][IDX_W-1:0]       chk_idx,
   output logic [NUM_TYPES-1:0]                  chk_bad
);
   localparam int CMP_W = (IDX_W > LIM_W ? IDX_W : LIM_W) + 1;

   function automatic int owner_of(input int code);
      int found;
      found = -1;
      for (int r = REG_CNT - 1; r >= 0; r--)
         if (int'(TYPE_MAP[r*TYPE_W +: TYPE_W]) == code) found = r;
      return found;
   endfunction

   generate
      if (NUM_TYPES < 1 || NUM_TYPES >= (1 << TYPE_W)) begin : g_bad_types
         $error("NUM_TYPES out of range");
      end
   endgenerate

   desc_t             reg_desc  [REG_CNT];
   logic [LIM_W-1:0]  reg_limit [REG_CNT];
   logic [DATA_W-1:0] reg_rd    [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      localparam int CODE = int'(TYPE_MAP[i*TYPE_W +: TYPE_W]);
      tbr_desc_reg #(.TYPE_CODE(CODE)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en && (reg_sel == SEL_W'(i))),
         .wr_data (wr_data),
         .rd_data (reg_rd[i]),
         .desc    (reg_desc[i])
      );
      if (CODE == 0) begin : g_nolim
         assign reg_limit[i] = '0;
      end else if (CODE > NUM_TYPES) begin : g_badcode
         $error("type code without a type entry");
         assign reg_limit[i] = '0;
      end else begin : g_lim
         tbr_limit_calc #(
            .PAGE_LOG2 (PAGE_LOG2),
            .L1_LOG2   (L1_LOG2),
            .ESZ_LOG2  (int'(TYPE_ESZ_LOG2[CODE-1])),
            .ID_BITS   (int'(TYPE_ID_BITS[CODE-1])),
            .LIM_W     (LIM_W)
         ) u_calc (
            .desc  (reg_desc[i]),
            .limit (reg_limit[i])
         );
         // R9
         invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_desc[i].valid |-> reg_limit[i] == '0);
         // R8
         id_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reg_limit[i] <= (LIM_W'(1) << TYPE_ID_BITS[CODE-1]));
      end
   end

   assign rd_data = reg_rd[reg_sel];

   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
      localparam int OWNER = owner_of(t + 1);
      if (OWNER < 0) begin : g_none
         assign tbl_base[t]      = '0;
         assign tbl_two_level[t] = 1'b0;
         assign tbl_limit[t]     = '0;
      end else begin : g_own
         assign tbl_base[t]      = reg_desc[OWNER].base;
         assign tbl_two_level[t] = reg_desc[OWNER].two_lvl;
         assign tbl_limit[t]     = reg_limit[OWNER];
      end
      assign chk_bad[t] = CMP_W'(chk_idx[t]) >= CMP_W'(tbl_limit[t]);

      // R11
      zero_limit_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tbl_limit[t] == '0) |-> chk_bad[t]);
   end

   // R3
   absent_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (TYPE_MAP[reg_sel*TYPE_W +: TYPE_W] == '0) |-> rd_data == '0);
endmodule

// File: tb/test_tbr_bank.sv
module test_tbr_bank;
   localparam int CLK_PERIOD = 10;

   logic              clk = 0;
   logic              rst_n = 0;
   logic [2:0]        reg_sel = 0;
   logic              wr_en = 0;
   logic [63:0]       wr_data = 0;
   logic [63:0]       rd_data;
   logic [1:0][39:0]  tbl_base;
   logic [1:0]        tbl_two_level;
   logic [1:0][16:0]  tbl_limit;
   logic [1:0][31:0]  chk_idx = '0;
   logic [1:0]        chk_bad;

   int errs = 0;
   int checks = 0;
   logic [63:0] sh [8];

   localparam logic [63:0] WMASK = 64'hC00F_FFFF_FFFF_F0FF;

   always #(CLK_PERIOD/2) clk = ~clk;

   tbr_bank i_tbr_bank (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .tbl_base(tbl_base),
      .tbl_two_level(tbl_two_level), .tbl_limit(tbl_limit),
      .chk_idx(chk_idx), .chk_bad(chk_bad)
   );

   function automatic int code_of(input int r);
      return r == 0 ? 1 : (r == 1 ? 2 : 0);
   endfunction

   function automatic logic [63:0] exp_read(input int r);
      if (code_of(r) == 0) return 64'h0;
      return (sh[r] & WMASK) | (64'(code_of(r)) << 56);
   endfunction

   function automatic longint exp_limit(input int t);
      logic [63:0] v;
      longint cnt, idl;
      int esz;
      v = sh[t];
      if (!v[63]) return 0;
      esz = (t == 0) ? 3 : 4;
      idl = (t == 0) ? 65536 : 4096;
      cnt = longint'(v[7:0]) + 1;
      cnt = cnt << (12 - esz);
      if (v[62]) cnt = cnt << 9;
      return cnt < idl ? cnt : idl;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input int r, input logic [63:0] d);
      @(negedge clk);
      reg_sel = 3'(r); wr_data = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
      if (code_of(r) != 0) sh[r] = d;
   endtask

   task automatic check_read(input int r, input string req);
      reg_sel = 3'(r);
      #1;
      check(req, longint'(rd_data), longint'(exp_read(r)));
   endtask

   task automatic check_type(input int t, input logic [31:0] idx);
      longint lim;
      lim = exp_limit(t);
      chk_idx[t] = idx;
      #1;
      check("R8 limit", longint'(tbl_limit[t]), lim);
      check("R11 chk_bad", longint'(chk_bad[t]), longint'(longint'(idx) >= lim));
      check("R10 base", longint'(tbl_base[t]), longint'(sh[t][51:12]));
      check("R10 two_level", longint'(tbl_two_level[t]), longint'(sh[t][62]));
   endtask

   task automatic check_bounds(input int t, input string req);
      longint lim;
      lim = exp_limit(t);
      check(req, longint'(tbl_limit[t]), lim);
      if (lim > 0) check_type(t, 32'(lim - 1));
      check_type(t, 32'(lim));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 8; i++) sh[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R5 and R1: reset contents
      for (int i = 0; i < 8; i++) check_read(i, "R5 reset read");
      check("R5 limit dev", longint'(tbl_limit[0]), 0);
      check("R5 limit coll", longint'(tbl_limit[1]), 0);

      // R6: flat device table, one page -> 512
      do_write(0, 64'h8000_0000_0012_3000);
      check_bounds(0, "R6 flat dev");
      check_read(0, "R4 readback");
      // R8: 256 pages device flat -> capped at 65536
      do_write(0, 64'h8000_0000_0000_00FF);
      check_bounds(0, "R8 dev cap");
      // R7: two-level collection, one page -> capped 4096; flat 8 pages -> 2048
      do_write(1, 64'hC000_0000_0000_0000);
      check_bounds(1, "R7 two-level coll");
      do_write(1, 64'h8000_0000_0000_0007);
      check_bounds(1, "R6 flat coll");
      do_write(1, 64'h8000_0000_0000_003F);
      check_bounds(1, "R8 coll cap");
      // R2: type bits written as ones are ignored
      do_write(0, 64'hFFFF_FFFF_FFFF_FFFF);
      check_read(0, "R2 type read-only");
      check_bounds(0, "R7 two-level dev");
      // R9: valid clear
      do_write(0, 64'h4000_0000_0000_00FF);
      check_bounds(0, "R9 invalid limit");
      check_type(0, 0);
      // R3: absent registers
      do_write(5, 64'hFFFF_FFFF_FFFF_FFFF);
      check_read(5, "R3 absent read");
      check_bounds(0, "R3 absent no effect");

      // R12: write and check in the same cycle
      do_write(0, 64'h8000_0000_0000_0000);
      @(negedge clk);
      reg_sel = 0; wr_data = 64'h8000_0000_0000_0001; wr_en = 1;
      chk_idx[0] = 32'd512;
      #1;
      check("R12 old limit used", longint'(chk_bad[0]), 1);
      @(negedge clk);
      wr_en = 0;
      sh[0] = 64'h8000_0000_0000_0001;
      #1;
      check("R12 new limit after edge", longint'(chk_bad[0]), 0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int r;
         logic [63:0] d;
         r = int'($urandom_range(0, 7));
         d = {$urandom(), $urandom()};
         if ($urandom_range(0, 3) != 0) d[63] = 1'b1;
         do_write(r, d);
         check_read(r, "R4 random read");
         check_bounds(0, "R8 random dev");
         check_bounds(1, "R8 random coll");
         check_type(int'($urandom_range(0, 1)), $urandom_range(0, 70000));
      end

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule